// File: doc/BRIEF.md
# Shared-Pin Status LED Refresh Controller

The controller drives four status LEDs, two per line channel (one green and one yellow each), over pins that are also used by a flash SPI master. It refreshes the LEDs one at a time. Each LED has a 2-bit mode: dark, lit, slow blink or fast blink. After the last LED step, each refresh cycle spends one step reading a push button on the shared pins. A free-running prescaler supplies both blink phases.

Software pauses the controller with a handshake. To take the pins, it clears the run bit and polls the active flag. The controller always finishes the cycle it has started, drops active on the cycle boundary, and releases the pin drive through an output-enable handoff signal. After the SPI access, software sets run again. A new cycle starts only when run is set at the boundary.

Top module: `led_scan_ctrl`

## Requirements
- R1: While `rst_n` is low, all of the following read as zero: the modes, run, active, the button status, `led_oe` and `led_o`. The internal reset is released on the second rising clock edge after `rst_n` goes high.
- R2: A write (`ctl_wr` high at a clock edge) loads `ctl_wdata[7:0]` into the modes and `ctl_wdata[8]` into run. The modes are laid out as follows, each driving the `led_o` bit shown: bits 1:0 channel-0 green → `led_o[0]`, bits 3:2 channel-0 yellow → `led_o[1]`, bits 5:4 channel-1 green → `led_o[2]`, bits 7:6 channel-1 yellow → `led_o[3]`. The values read back on `ctl_rdata[8:0]` after that edge.
- R3: The mode encoding is 00 dark, 01 lit, 10 slow blink, 11 fast blink.
- R4: The prescaler is cleared by reset and counts every clock after the internal reset is released. Fast blink lights the LED while prescaler bit 7 is 1. Slow blink lights it while bit 10 is 1, so the slow phase toggles one eighth as often as the fast phase.
- R5: If the controller is idle at an edge where run is 1, a refresh cycle starts at the next edge. A cycle has five steps of four clocks each. In step k (k = 0..3), `led_o` shows only bit k, and only if LED k is lit per R3/R4.
- R6: `led_oe` is 1 exactly during steps 0..3. It is 0 during the button step (step 4) and while idle. `led_o` is zero whenever `led_oe` is 0.
- R7: If run is cleared during a cycle, the cycle still completes. Active (`ctl_rdata[9]`) stays 1 until the boundary edge that ends step 4, then falls.
- R8: If run is still 1 at the boundary, the next cycle starts at step 0 with no idle clock, so active stays 1.
- R9: The button input is captured on the last clock of step 4 and shown on `ctl_rdata[10]`. It holds its value at all other times.
- R10: `ctl_rdata[9]` is 1 exactly while a refresh cycle is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 9 | Modes [7:0], run [8] |
| ctl_rdata | output | 11 | Modes [7:0], run [8], active [9], button [10] |
| btn_i | input | 1 | Push button level read through the shared pins |
| led_o | output | 4 | LED drive, one bit per LED |
| led_oe | output | 1 | Pin drive enable; low hands the pins to the other master |

## Verification
The checker assumes that writes are single-cycle strobes on clean, synchronous data. It also assumes `btn_i` changes only between clock edges, because the button has no synchronizer in front of its capture flop. The bench drives every input on the falling edge and holds it for a whole clock, so each write and each button level is seen at exactly one known edge. Each test vector clears run in the middle of a cycle. This exercises the handshake in the same way software uses it.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;
  typedef enum logic [1:0] {
    LED_DARK = 2'b00,
    LED_LIT  = 2'b01,
    LED_SLOW = 2'b10,
    LED_FAST = 2'b11
  } led_mode_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_SCAN = 1'b1
  } seq_state_e;
endpackage

// File: rtl/led_rst_sync.sv
module led_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_int_n = sync_q;
endmodule

// File: rtl/led_blink_presc.sv
module led_blink_presc #(
  parameter int PRESC_W  = 12,
  parameter int FAST_BIT = 7
) (
  input  logic clk,
  input  logic rst_n,
  output logic fast_ph,
  output logic slow_ph
);
  localparam int SLOW_BIT = FAST_BIT + 3;

  logic [PRESC_W-1:0] cnt_q;
  logic [PRESC_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + PRESC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign fast_ph = cnt_q[FAST_BIT];
  assign slow_ph = cnt_q[SLOW_BIT];
endmodule

// File: rtl/led_mode_decode.sv
module led_mode_decode
  import led_scan_pkg::*;
#(
  parameter int NUM_LEDS = 4
) (
  input  logic [2*NUM_LEDS-1:0] modes,
  input  logic                  fast_ph,
  input  logic                  slow_ph,
  output logic [NUM_LEDS-1:0]   lit
);
  for (genvar g = 0; g < NUM_LEDS; g++) begin : g_led
    led_mode_e mode;
    assign mode = led_mode_e'(modes[2*g +: 2]);
    always_comb begin
      case (mode)
        LED_LIT:  lit[g] = 1'b1;
        LED_SLOW: lit[g] = slow_ph;
        LED_FAST: lit[g] = fast_ph;
        default:  lit[g] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/led_scan_seq.sv
module led_scan_seq
  import led_scan_pkg::*;
#(
  parameter int NUM_LEDS = 4,
  parameter int STEP_LEN = 4,
  localparam int STEP_W  = $clog2(NUM_LEDS + 1),
  localparam int TICK_W  = $clog2(STEP_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  output logic              active_o,
  output logic              drive_o,
  output logic              sample_o,
  output logic [STEP_W-1:0] step_o
);
  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [TICK_W-1:0] tick_q, tick_d;
  logic              last_tick;
  logic              last_step;

  assign last_tick = (tick_q == TICK_W'(STEP_LEN - 1));
  assign last_step = (step_q == STEP_W'(NUM_LEDS));

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    tick_d  = tick_q;
    case (state_q)
      SEQ_IDLE: begin
        if (run_i) begin
          state_d = SEQ_SCAN;
          step_d  = '0;
          tick_d  = '0;
        end
      end
      default: begin
        if (last_tick) begin
          tick_d = '0;
          if (last_step) begin
            step_d = '0;
            if (!run_i) state_d = SEQ_IDLE;
          end else begin
            step_d = step_q + STEP_W'(1);
          end
        end else begin
          tick_d = tick_q + TICK_W'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      step_q  <= '0;
      tick_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      tick_q  <= tick_d;
    end
  end

  assign active_o = (state_q == SEQ_SCAN);
  assign drive_o  = active_o && !last_step;
  assign sample_o = active_o && last_step && last_tick;
  assign step_o   = step_q;
endmodule

// File: rtl/led_scan_ctrl.sv
module led_scan_ctrl #(
  parameter int NUM_CH      = 2,
  parameter int LEDS_PER_CH = 2,
  parameter int STEP_LEN    = 4,
  parameter int PRESC_W     = 12,
  parameter int FAST_BIT    = 7,
  localparam int NUM_LEDS   = NUM_CH * LEDS_PER_CH,
  localparam int MODE_W     = 2 * NUM_LEDS,
  localparam int CFG_W      = MODE_W + 1,
  localparam int RD_W       = MODE_W + 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_wr,
  input  logic [CFG_W-1:0]    ctl_wdata,
  output logic [RD_W-1:0]     ctl_rdata,
  input  logic                btn_i,
  output logic [NUM_LEDS-1:0] led_o,
  output logic                led_oe
);
  localparam int STEP_W = $clog2(NUM_LEDS + 1);

  logic              rst_int_n;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              run_q, run_d;
  logic              btn_q, btn_d;
  logic              fast_ph, slow_ph;
  logic [NUM_LEDS-1:0] lit;
  logic              active, drive, sample;
  logic [STEP_W-1:0] step;

  led_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  led_blink_presc #(
    .PRESC_W  (PRESC_W),
    .FAST_BIT (FAST_BIT)
  ) u_presc (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .fast_ph (fast_ph),
    .slow_ph (slow_ph)
  );

  led_mode_decode #(
    .NUM_LEDS (NUM_LEDS)
  ) u_dec (
    .modes   (mode_q),
    .fast_ph (fast_ph),
    .slow_ph (slow_ph),
    .lit     (lit)
  );

  led_scan_seq #(
    .NUM_LEDS (NUM_LEDS),
    .STEP_LEN (STEP_LEN)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run_i    (run_q),
    .active_o (active),
    .drive_o  (drive),
    .sample_o (sample),
    .step_o   (step)
  );

  always_comb begin
    mode_d = mode_q;
    run_d  = run_q;
    if (ctl_wr) begin
      mode_d = ctl_wdata[MODE_W-1:0];
      run_d  = ctl_wdata[MODE_W];
    end
    btn_d = sample ? btn_i : btn_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode_q <= '0;
      run_q  <= 1'b0;
      btn_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      run_q  <= run_d;
      btn_q  <= btn_d;
    end
  end

  for (genvar g = 0; g < NUM_LEDS; g++) begin : g_pin
    assign led_o[g] = drive && (step == STEP_W'(g)) && lit[g];
  end

  assign led_oe    = drive;
  assign ctl_rdata = {btn_q, active, run_q, mode_q};
endmodule

// File: rtl/led_scan_ctrl_chk.sv
module led_scan_ctrl_chk #(
  parameter int NUM_LEDS = 4,
  parameter int RD_W     = 11
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_LEDS-1:0] led_o,
  input logic                led_oe,
  input logic [RD_W-1:0]     ctl_rdata
);
  localparam int RUN_B  = RD_W - 3;
  localparam int ACT_B  = RD_W - 2;
  localparam int BTN_B  = RD_W - 1;

  AST_ONE_LED_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(led_o)); // R5
  AST_DARK_WITHOUT_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !led_oe |-> (led_o == '0)); // R6
  AST_OE_ONLY_WHEN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    led_oe |-> ctl_rdata[ACT_B]); // R10
  AST_STOP_NEEDS_RUN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_rdata[ACT_B]) |-> !$past(ctl_rdata[RUN_B])); // R7
  AST_START_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_rdata[ACT_B]) |-> $past(ctl_rdata[RUN_B])); // R5
  AST_BTN_HOLDS_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctl_rdata[ACT_B]) |-> $stable(ctl_rdata[BTN_B])); // R9
  AST_OE_DROPS_BEFORE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_rdata[ACT_B]) |-> !$past(led_oe)); // R6
endmodule

bind led_scan_ctrl led_scan_ctrl_chk #(
  .NUM_LEDS (NUM_LEDS),
  .RD_W     (RD_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .led_o     (led_o),
  .led_oe    (led_oe),
  .ctl_rdata (ctl_rdata)
);

// File: tb/led_scan_ctrl_tb.sv
module led_scan_ctrl_tb_top;
  localparam int STEP      = 4;
  localparam int NSTEPS    = 5;
  localparam int CYC       = STEP * NSTEPS;
  localparam int NVEC      = 6;
  // {button level, modes}
  localparam logic [8:0] VEC [NVEC] = '{
    9'h100, 9'h055, 9'h1E4, 9'h0FF, 9'h1AA, 9'h01B
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_wr;
  logic [8:0]  ctl_wdata;
  logic [10:0] ctl_rdata;
  logic        btn_i;
  logic [3:0]  led_o;
  logic        led_oe;

  int checks = 0;
  int fails  = 0;
  int rel;
  int unsigned cnt;

  always #10 clk = ~clk;

  led_scan_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .ctl_rdata (ctl_rdata),
    .btn_i     (btn_i),
    .led_o     (led_o),
    .led_oe    (led_oe)
  );

  // clock count since internal reset release (R1, R4)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel <= 0;
      cnt <= 0;
    end else if (rel < 2) rel <= rel + 1;
    else cnt <= cnt + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic lit(input logic [1:0] m, input int unsigned c);
    case (m)
      2'b01:   return 1'b1;
      2'b10:   return c[10];
      2'b11:   return c[7];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [3:0] exp_led(input logic [7:0] m, input int s, input int unsigned c);
    logic [3:0] r = '0;
    for (int k = 0; k < 4; k++)
      if (s == k) r[k] = lit(m[2*k +: 2], c);
    return r;
  endfunction

  task automatic write(input logic [8:0] d);
    ctl_wdata = d;
    ctl_wr    = 1'b1;
    @(negedge clk);
    ctl_wr    = 1'b0;
  endtask

  task automatic run_vec(input logic [7:0] m, input logic b);
    write({1'b1, m});
    check("R2 modes", ctl_rdata[7:0], m);
    check("R2 run", ctl_rdata[8], 1'b1);
    check("R5 not yet active", ctl_rdata[9], 1'b0);
    for (int i = 0; i < CYC; i++) begin
      if (i == 5) begin ctl_wdata = {1'b0, m}; ctl_wr = 1'b1; end
      if (i == 6) ctl_wr = 1'b0;
      if (i == 16) btn_i = b;
      @(negedge clk);
      check("R3 R4 R5 led", led_o, exp_led(m, i / STEP, cnt));
      check("R6 oe", led_oe, (i / STEP) < 4);
      check("R7 R10 active", ctl_rdata[9], 1'b1);
    end
    @(negedge clk);
    check("R7 idle at boundary", ctl_rdata[9], 1'b0);
    check("R6 oe idle", led_oe, 1'b0);
    check("R6 led idle", led_o, 4'h0);
    check("R9 button captured", ctl_rdata[10], b);
    btn_i = ~b;
    repeat (3) @(negedge clk);
    check("R9 button held", ctl_rdata[10], b);
    check("R7 stays idle", ctl_rdata[9], 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctl_wr = 1'b0; ctl_wdata = '0; btn_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 rdata in reset", ctl_rdata, 11'h0);
    check("R1 oe in reset", led_oe, 1'b0);
    check("R1 led in reset", led_o, 4'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // write during the synchronizer window is lost (R1)
    write(9'h155);
    check("R1 write before release ignored", ctl_rdata, 11'h0);
    repeat (2) @(negedge clk);
    check("R1 idle after release", ctl_rdata[9], 1'b0);

    for (int v = 0; v < NVEC; v++) begin
      repeat (37 * v + 1) @(negedge clk);
      run_vec(VEC[v][7:0], VEC[v][8]);
    end

    // R8: run held set, back-to-back cycles
    repeat (300) @(negedge clk);
    write(9'h1E7);
    for (int i = 0; i < CYC + 4; i++) begin
      @(negedge clk);
      check("R8 active no gap", ctl_rdata[9], 1'b1);
      check("R8 led", led_o, exp_led(8'hE7, (i % CYC) / STEP, cnt));
    end
    write(9'h0E7);
    repeat (CYC + 2) @(negedge clk);
    check("R7 stopped after run clear", ctl_rdata[9], 1'b0);
    check("R2 run readback", ctl_rdata[8], 1'b0);

    // R4: slow blink over a long window, LED 0 only
    write(9'h102);
    for (int i = 0; i < 2200; i++) begin
      @(negedge clk);
      if (((i % CYC) / STEP) == 0)
        check("R4 slow phase", led_o, {3'b000, cnt[10]});
    end
    write(9'h002);
    repeat (CYC + 2) @(negedge clk);

    // R1: reset in the middle of a cycle
    write(9'h1FF);
    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", ctl_rdata, 11'h0);
    check("R1 async reset oe", led_oe, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule